// File: doc/BRIEF.md
# SIMD Cross-Lane Permutation Unit

This unit rearranges a 64-lane vector operand of 32-bit elements before it reaches a vector ALU. A 9-bit control code picks one of many lane patterns: 256 permutations inside each group of four lanes, shifts and rotates confined to a 16-lane row, single-step shifts and rotates across the whole wave, mirrors, and broadcasts from one row into the next. Each destination lane gathers its value from one source lane chosen by the pattern.

A row mask (one bit per 16-lane row) and a bank mask (one bit per 4-lane bank inside a row) switch destination lanes off. A lane that is switched off is not written. A lane whose source falls outside the row or wave, or whose source lane is inactive in the execution mask, is either written with zero or not written, as the bound-control bit selects. The unit sends a write-enable vector with the data, so the register file keeps its old value in every lane that is not written. A code outside the legal set raises an illegal flag, and nothing is written for that operation.

The gather network is combinational and feeds one output register. An operation is accepted in any cycle in which `valid_i` is high, and its result appears one cycle later.

Top module: `lane_xbar`

## Requirements
- R1: Codes 0x000 to 0x0FF permute within each aligned group of four lanes. Destination lane d takes lane (d & ~3) | ((code >> 2*(d%4)) & 3).
- R2: Codes 0x101..0x10F (n = code[3:0]) fill row offset k from offset k+n of the same 16-lane row. Codes 0x111..0x11F fill offset k from offset k-n. A source beyond either end of the row is out of bounds.
- R3: Codes 0x121..0x12F fill row offset k from offset (k-n) mod 16 of the same row.
- R4: Code 0x130 fills lane d from d+1, with lane 63 out of bounds. Code 0x134 fills it from (d+1) mod 64. Code 0x138 fills it from d-1, with lane 0 out of bounds. Code 0x13C fills it from (d-1) mod 64.
- R5: Code 0x140 fills row offset k from offset 15-k. Code 0x141 fills position j of each aligned 8-lane half row from position 7-j.
- R6: For code 0x142, every lane at or above 16 takes the last lane of the previous row. For code 0x143, every lane at or above 32 takes lane 31. Under both codes, all other lanes take their own value.
- R7: Lane d is disabled when row-mask bit d/16 or bank-mask bit (d%16)/4 is 0. A disabled lane has write enable 0 and data 0, whatever the bound-control bit and the execution mask.
- R8: For an enabled lane whose source is out of bounds, or whose source lane has execution-mask bit 0: with bound control 1 the lane is written with zero (enable 1, data 0); with bound control 0 it is not written (enable 0, data 0). Otherwise the lane is written with the source value.
- R9: Codes 0x100, 0x110, 0x120, 0x131..0x133, 0x135..0x137, 0x139..0x13B, 0x13D..0x13F and 0x144..0x1FF are illegal. For these codes `illegal_o` is 1 and all write enables and data are 0.
- R10: The result of an operation accepted at a clock edge appears after that edge, with `valid_o` high for one cycle per accepted operation. Back-to-back operations are accepted every cycle. When `valid_i` is low, `valid_o` falls and data, enables and flag hold their values.
- R11: After reset, `valid_o`, `illegal_o`, `wen_o` and `data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation accepted this cycle |
| ctrl_i | input | 9 | Pattern control code |
| row_mask_i | input | 4 | Per-row lane enable |
| bank_mask_i | input | 4 | Per-bank lane enable, applied in every row |
| bound_ctrl_i | input | 1 | 1: zero-fill unusable sources; 0: skip the write |
| exec_mask_i | input | 64 | Active source lanes |
| src_i | input | 2048 | Source operand, lane d at bits [32d+31:32d] |
| valid_o | output | 1 | Result valid |
| data_o | output | 2048 | Permuted operand, same lane packing as src_i |
| wen_o | output | 64 | Per-lane write enable |
| illegal_o | output | 1 | Control code was illegal |

## Verification
The hardest case to reach is a lane that is enabled but whose source is unusable, and there are two different causes: the source lies past a row or wave edge, or the source lane is inactive while the destination lane is active. The stimulus reaches both. It pairs edge-crossing shift codes with each bound-control setting, and it uses alternating execution masks together with quad patterns that cross lanes, so that active lanes read inactive ones. Partial row and bank masks are then laid over that traffic, to check that disabling a lane takes priority over zero-filling it.

// File: rtl/lane_xbar_pkg.sv
package lane_xbar_pkg;
  typedef enum logic [3:0] {
    OP_QUAD, OP_ROW_SHL, OP_ROW_SHR, OP_ROW_ROR,
    OP_WAVE_SHL, OP_WAVE_ROL, OP_WAVE_SHR, OP_WAVE_ROR,
    OP_MIRROR, OP_HALF_MIRROR, OP_BCAST_ROW, OP_BCAST_HALF,
    OP_ILLEGAL
  } xop_e;

  localparam int CTRL_W = 9;
  localparam int AMT_W  = 4;
endpackage

// File: rtl/xbar_ctrl_decode.sv
module xbar_ctrl_decode
  import lane_xbar_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output xop_e              op_o,
  output logic [AMT_W-1:0]  amt_o,
  output logic              illegal_o
);
  logic [AMT_W-1:0] lo;
  assign lo    = ctrl_i[AMT_W-1:0];
  assign amt_o = lo;

  always_comb begin
    op_o = OP_ILLEGAL;
    if (!ctrl_i[8]) begin
      op_o = OP_QUAD;
    end else begin
      case (ctrl_i[7:4])
        4'h0: if (lo != '0) op_o = OP_ROW_SHL;
        4'h1: if (lo != '0) op_o = OP_ROW_SHR;
        4'h2: if (lo != '0) op_o = OP_ROW_ROR;
        4'h3: case (lo)
                4'h0:    op_o = OP_WAVE_SHL;
                4'h4:    op_o = OP_WAVE_ROL;
                4'h8:    op_o = OP_WAVE_SHR;
                4'hC:    op_o = OP_WAVE_ROR;
                default: op_o = OP_ILLEGAL;
              endcase
        4'h4: case (lo)
                4'h0:    op_o = OP_MIRROR;
                4'h1:    op_o = OP_HALF_MIRROR;
                4'h2:    op_o = OP_BCAST_ROW;
                4'h3:    op_o = OP_BCAST_HALF;
                default: op_o = OP_ILLEGAL;
              endcase
        default: op_o = OP_ILLEGAL;
      endcase
    end
  end

  assign illegal_o = (op_o == OP_ILLEGAL);
endmodule

// File: rtl/xbar_lane_map.sv
module xbar_lane_map
  import lane_xbar_pkg::*;
#(
  parameter int LANE      = 0,
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  parameter int LW        = 6
) (
  input  xop_e             op_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [7:0]       quad_i,
  output logic [LW-1:0]    src_o,
  output logic             oob_o
);
  localparam int OFS   = LANE % ROW_LANES;
  localparam int RBASE = LANE - OFS;
  localparam int QPOS  = LANE % 4;
  localparam int HPOS  = LANE % 8;

  always_comb begin
    int s;
    int n;
    logic oob;
    n   = int'(amt_i);
    s   = LANE;
    oob = 1'b0;
    case (op_i)
      OP_QUAD:        s = LANE - QPOS + int'((quad_i >> (2 * QPOS)) & 8'h3);
      OP_ROW_SHL:     if (OFS + n > ROW_LANES - 1) oob = 1'b1; else s = LANE + n;
      OP_ROW_SHR:     if (OFS < n) oob = 1'b1; else s = LANE - n;
      OP_ROW_ROR:     s = RBASE + ((OFS - n + ROW_LANES) % ROW_LANES);
      OP_WAVE_SHL:    if (LANE == LANES - 1) oob = 1'b1; else s = LANE + 1;
      OP_WAVE_ROL:    s = (LANE + 1) % LANES;
      OP_WAVE_SHR:    if (LANE == 0) oob = 1'b1; else s = LANE - 1;
      OP_WAVE_ROR:    s = (LANE + LANES - 1) % LANES;
      OP_MIRROR:      s = RBASE + ROW_LANES - 1 - OFS;
      OP_HALF_MIRROR: s = LANE - HPOS + 7 - HPOS;
      OP_BCAST_ROW:   if (LANE >= ROW_LANES) s = RBASE - 1;
      OP_BCAST_HALF:  if (LANE >= LANES / 2) s = LANES / 2 - 1;
      default:        s = LANE;
    endcase
    src_o = LW'(s);
    oob_o = oob;
  end
endmodule

// File: rtl/lane_xbar.sv
module lane_xbar
  import lane_xbar_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  parameter int DW         = 32,
  localparam int ROWS      = LANES / ROW_LANES,
  localparam int BANKS     = ROW_LANES / BANK_LANES,
  localparam int LW        = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  input  logic [ROWS-1:0]     row_mask_i,
  input  logic [BANKS-1:0]    bank_mask_i,
  input  logic                bound_ctrl_i,
  input  logic [LANES-1:0]    exec_mask_i,
  input  logic [LANES*DW-1:0] src_i,
  output logic                valid_o,
  output logic [LANES*DW-1:0] data_o,
  output logic [LANES-1:0]    wen_o,
  output logic                illegal_o
);
  xop_e             op;
  logic [AMT_W-1:0] amt;
  logic             illegal;

  xbar_ctrl_decode u_dec (
    .ctrl_i    (ctrl_i),
    .op_o      (op),
    .amt_o     (amt),
    .illegal_o (illegal)
  );

  logic [LANES*DW-1:0] nxt_data;
  logic [LANES-1:0]    nxt_wen;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] src_idx;
    logic          oob;
    logic          lane_on;
    logic          src_ok;
    logic          lane_wen;
    logic [DW-1:0] lane_dat;

    xbar_lane_map #(
      .LANE      (g),
      .LANES     (LANES),
      .ROW_LANES (ROW_LANES),
      .LW        (LW)
    ) u_map (
      .op_i   (op),
      .amt_i  (amt),
      .quad_i (ctrl_i[7:0]),
      .src_o  (src_idx),
      .oob_o  (oob)
    );

    assign lane_on = row_mask_i[g / ROW_LANES] && bank_mask_i[(g % ROW_LANES) / BANK_LANES];
    assign src_ok  = !oob && exec_mask_i[src_idx];

    // disabled beats bound control; bound control only rescues unusable sources
    always_comb begin
      lane_wen = 1'b0;
      lane_dat = '0;
      if (!illegal && lane_on) begin
        if (src_ok) begin
          lane_wen = 1'b1;
          lane_dat = src_i[src_idx*DW +: DW];
        end else if (bound_ctrl_i) begin
          lane_wen = 1'b1;
        end
      end
    end

    assign nxt_wen[g]            = lane_wen;
    assign nxt_data[g*DW +: DW]  = lane_dat;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      wen_o     <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o    <= nxt_data;
        wen_o     <= nxt_wen;
        illegal_o <= illegal;
      end
    end
  end

  a_r10_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(wen_o) && $stable(illegal_o)));
  a_r9_illegal_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (wen_o == '0));
  a_r9_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i == 9'h100) |=> illegal_o);
  a_r7_row0_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !row_mask_i[0]) |=> (wen_o[ROW_LANES-1:0] == '0));
  a_r8_no_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bound_ctrl_i && exec_mask_i == '0) |=> (wen_o == '0));
  a_r8_bc_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bound_ctrl_i && (&row_mask_i) && (&bank_mask_i) && !ctrl_i[8]) |=> (&wen_o));
endmodule

// File: tb/lane_xbar_test.sv
`timescale 1ns/1ps
module lane_xbar_test;
  localparam int L = 64;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic [8:0]      ctrl_i = '0;
  logic [3:0]      row_mask_i = '0;
  logic [3:0]      bank_mask_i = '0;
  logic            bound_ctrl_i = 1'b0;
  logic [L-1:0]    exec_mask_i = '0;
  logic [L*DW-1:0] src_i = '0;
  logic            valid_o;
  logic [L*DW-1:0] data_o;
  logic [L-1:0]    wen_o;
  logic            illegal_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lane_xbar uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .ctrl_i(ctrl_i),
    .row_mask_i(row_mask_i), .bank_mask_i(bank_mask_i), .bound_ctrl_i(bound_ctrl_i),
    .exec_mask_i(exec_mask_i), .src_i(src_i), .valid_o(valid_o), .data_o(data_o),
    .wen_o(wen_o), .illegal_o(illegal_o)
  );

  function automatic logic [L*DW-1:0] mk_src(input logic [15:0] seed);
    logic [L*DW-1:0] v;
    for (int i = 0; i < L; i++) v[i*DW +: DW] = {seed, 8'(i), ~8'(i)};
    return v;
  endfunction

  function automatic bit is_illegal(input logic [8:0] c);
    int x;
    x = int'(c);
    if (x <= 'hFF) return 0;
    if (x >= 'h101 && x <= 'h10F) return 0;
    if (x >= 'h111 && x <= 'h11F) return 0;
    if (x >= 'h121 && x <= 'h12F) return 0;
    if (x == 'h130 || x == 'h134 || x == 'h138 || x == 'h13C) return 0;
    if (x >= 'h140 && x <= 'h143) return 0;
    return 1;
  endfunction

  function automatic void exp_src(input logic [8:0] c, input int d, output int s, output bit oob);
    int x, o, rb, n, h;
    x = int'(c); o = d % 16; rb = d - o; n = x % 16; h = d % 8;
    s = d; oob = 0;
    if (x <= 'hFF) s = (d / 4) * 4 + ((x >> (2 * (d % 4))) % 4);
    else if (x >= 'h101 && x <= 'h10F) begin if (o + n > 15) oob = 1; else s = d + n; end
    else if (x >= 'h111 && x <= 'h11F) begin if (o < n) oob = 1; else s = d - n; end
    else if (x >= 'h121 && x <= 'h12F) s = rb + (o - n + 16) % 16;
    else if (x == 'h130) begin if (d == 63) oob = 1; else s = d + 1; end
    else if (x == 'h134) s = (d + 1) % 64;
    else if (x == 'h138) begin if (d == 0) oob = 1; else s = d - 1; end
    else if (x == 'h13C) s = (d + 63) % 64;
    else if (x == 'h140) s = rb + 15 - o;
    else if (x == 'h141) s = d - h + 7 - h;
    else if (x == 'h142) begin if (d >= 16) s = rb - 1; end
    else if (x == 'h143) begin if (d >= 32) s = 31; end
  endfunction

  function automatic void model(input logic [8:0] c, input logic [3:0] rm, input logic [3:0] bm,
                                input logic bc, input logic [L-1:0] ex, input logic [L*DW-1:0] src,
                                output logic [L*DW-1:0] ed, output logic [L-1:0] ew, output logic eil);
    int s; bit oob;
    ed = '0; ew = '0; eil = is_illegal(c);
    for (int d = 0; d < L; d++) begin
      exp_src(c, d, s, oob);
      if (!eil && rm[d / 16] && bm[(d % 16) / 4]) begin
        if (!oob && ex[s]) begin ew[d] = 1'b1; ed[d*DW +: DW] = src[s*DW +: DW]; end
        else if (bc) ew[d] = 1'b1;
      end
    end
  endfunction

  task automatic chk1(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_data(input string req, input logic [L*DW-1:0] exp);
    int bad;
    bad = -1;
    for (int d = L - 1; d >= 0; d--) if (data_o[d*DW +: DW] !== exp[d*DW +: DW]) bad = d;
    n_chk++;
    if (bad >= 0) begin
      n_bad++;
      $display("FAIL %s data lane %0d: actual %h expected %h", req, bad,
               data_o[bad*DW +: DW], exp[bad*DW +: DW]);
    end
  endtask

  task automatic drive(input logic [8:0] c, input logic [3:0] rm, input logic [3:0] bm,
                       input logic bc, input logic [L-1:0] ex, input logic [15:0] seed);
    ctrl_i = c; row_mask_i = rm; bank_mask_i = bm; bound_ctrl_i = bc;
    exec_mask_i = ex; src_i = mk_src(seed); valid_i = 1'b1;
  endtask

  task automatic run_op(input string req, input logic [8:0] c, input logic [3:0] rm,
                        input logic [3:0] bm, input logic bc, input logic [L-1:0] ex,
                        input logic [15:0] seed);
    logic [L*DW-1:0] ed; logic [L-1:0] ew; logic eil;
    @(negedge clk);
    drive(c, rm, bm, bc, ex, seed);
    model(c, rm, bm, bc, ex, src_i, ed, ew, eil);
    @(negedge clk);
    valid_i = 1'b0;
    chk1(req, "valid", 64'(valid_o), 64'd1);
    chk1(req, "illegal", 64'(illegal_o), 64'(eil));
    chk1(req, "wen", wen_o, ew);
    chk_data(req, ed);
  endtask

  task automatic t_reset;
    chk1("R11", "valid", 64'(valid_o), 64'd0);
    chk1("R11", "illegal", 64'(illegal_o), 64'd0);
    chk1("R11", "wen", wen_o, 64'd0);
    chk_data("R11", '0);
  endtask

  task automatic t_quad;
    run_op("R1", 9'h01B, 4'hF, 4'hF, 1'b0, '1, 16'h1111);
    run_op("R1", 9'h0E4, 4'hF, 4'hF, 1'b0, '1, 16'h2222);
    run_op("R1", 9'h000, 4'hF, 4'hF, 1'b0, '1, 16'h3333);
    run_op("R1", 9'h0C6, 4'hF, 4'hF, 1'b1, '1, 16'h3434);
  endtask

  task automatic t_row_shift;
    run_op("R2", 9'h101, 4'hF, 4'hF, 1'b1, '1, 16'h4444);
    run_op("R2", 9'h10F, 4'hF, 4'hF, 1'b0, '1, 16'h4545);
    run_op("R2", 9'h113, 4'hF, 4'hF, 1'b1, '1, 16'h4646);
    run_op("R2", 9'h118, 4'hF, 4'hF, 1'b0, '1, 16'h4747);
  endtask

  task automatic t_row_rot;
    run_op("R3", 9'h125, 4'hF, 4'hF, 1'b0, '1, 16'h5555);
    run_op("R3", 9'h12F, 4'hF, 4'hF, 1'b0, '1, 16'h5656);
  endtask

  task automatic t_wave;
    run_op("R4", 9'h130, 4'hF, 4'hF, 1'b1, '1, 16'h6661);
    run_op("R4", 9'h134, 4'hF, 4'hF, 1'b0, '1, 16'h6662);
    run_op("R4", 9'h138, 4'hF, 4'hF, 1'b0, '1, 16'h6663);
    run_op("R4", 9'h13C, 4'hF, 4'hF, 1'b0, '1, 16'h6664);
  endtask

  task automatic t_mirror;
    run_op("R5", 9'h140, 4'hF, 4'hF, 1'b0, '1, 16'h7771);
    run_op("R5", 9'h141, 4'hF, 4'hF, 1'b0, '1, 16'h7772);
  endtask

  task automatic t_bcast;
    run_op("R6", 9'h142, 4'hF, 4'hF, 1'b0, '1, 16'h8881);
    run_op("R6", 9'h143, 4'hF, 4'hF, 1'b0, '1, 16'h8882);
  endtask

  task automatic t_masks;
    run_op("R7", 9'h01B, 4'b1010, 4'b0110, 1'b1, 64'h5555_5555_5555_5555, 16'h9991);
    run_op("R7", 9'h143, 4'b0111, 4'b1001, 1'b0, '1, 16'h9992);
    run_op("R7", 9'h101, 4'b0000, 4'hF, 1'b1, '1, 16'h9993);
  endtask

  task automatic t_bound;
    run_op("R8", 9'h01B, 4'hF, 4'hF, 1'b0, 64'h5555_5555_5555_5555, 16'hAAA1);
    run_op("R8", 9'h01B, 4'hF, 4'hF, 1'b1, 64'h5555_5555_5555_5555, 16'hAAA2);
    run_op("R8", 9'h138, 4'hF, 4'hF, 1'b1, 64'hF0F0_0000_FFFF_0F0F, 16'hAAA3);
    run_op("R8", 9'h10C, 4'hF, 4'hF, 1'b0, 64'h0000_FFFF_0000_FFFF, 16'hAAA4);
  endtask

  task automatic t_illegal;
    run_op("R9", 9'h100, 4'hF, 4'hF, 1'b1, '1, 16'hBBB1);
    run_op("R9", 9'h110, 4'hF, 4'hF, 1'b1, '1, 16'hBBB2);
    run_op("R9", 9'h120, 4'hF, 4'hF, 1'b1, '1, 16'hBBB3);
    run_op("R9", 9'h135, 4'hF, 4'hF, 1'b1, '1, 16'hBBB4);
    run_op("R9", 9'h144, 4'hF, 4'hF, 1'b1, '1, 16'hBBB5);
    run_op("R9", 9'h1FF, 4'hF, 4'hF, 1'b1, '1, 16'hBBB6);
  endtask

  task automatic t_pipe;
    logic [L*DW-1:0] da, db; logic [L-1:0] wa, wb; logic ia, ib;
    @(negedge clk);
    drive(9'h13C, 4'hF, 4'hF, 1'b0, '1, 16'hCCC1);
    model(9'h13C, 4'hF, 4'hF, 1'b0, '1, src_i, da, wa, ia);
    @(negedge clk);
    chk1("R10", "valid A", 64'(valid_o), 64'd1);
    chk_data("R10", da);
    drive(9'h111, 4'hF, 4'b0011, 1'b1, '1, 16'hCCC2);
    model(9'h111, 4'hF, 4'b0011, 1'b1, '1, src_i, db, wb, ib);
    @(negedge clk);
    chk1("R10", "valid B", 64'(valid_o), 64'd1);
    chk1("R10", "wen B", wen_o, wb);
    chk_data("R10", db);
    valid_i = 1'b0;
    ctrl_i = 9'h100; row_mask_i = 4'h0; src_i = mk_src(16'hDEAD);
    @(negedge clk);
    chk1("R10", "valid idle", 64'(valid_o), 64'd0);
    chk1("R10", "wen hold", wen_o, wb);
    chk1("R10", "illegal hold", 64'(illegal_o), 64'(ib));
    chk_data("R10", db);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_quad();
    t_row_shift();
    t_row_rot();
    t_wave();
    t_mirror();
    t_bcast();
    t_masks();
    t_bound();
    t_illegal();
    t_pipe();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule